// File: doc/BRIEF.md
# Single-Digit Decimal Multiplier

This block multiplies two decimal digits, each held as a 4-bit binary-coded value from 0 to 9, and returns the product as a packed pair of decimal digits: a tens digit in the upper nibble and a units digit in the lower nibble. It is purely combinational, with no clock or reset, so the result follows the operands within the same cycle. It is meant as the digit cell inside a wider decimal multiply datapath, where many instances feed a decimal adder tree.

Internally the operands are ANDed into a 4x4 grid of partial-product bits. A two-level carry-save tree of half and full adders reduces each weight column to at most two bits. A ripple adder then merges those two rows into the binary product. An unrolled shift-and-add-3 network converts that binary value into decimal columns. Before each of the eight one-bit shifts, every decimal column that holds 5 or more is raised by 3. The hundreds column that the network also forms can never be non-zero for a valid digit pair, so it is dropped. Operand codes 10 to 15 are outside the contract and give an unspecified result.

Top module: `bcd_digit_mult`

## Requirements
- R1: For every pair of operands in 0..9, `prod_bcd[7:4]` equals floor(a*b/10) and `prod_bcd[3:0]` equals (a*b) mod 10.
- R2: When either operand is 0, `prod_bcd` is 8'h00.
- R3: The largest case, 9 times 9, gives `prod_bcd` = 8'h81.
- R4: For valid operands, neither nibble of `prod_bcd` ever exceeds 9.
- R5: Swapping the two operands leaves `prod_bcd` unchanged.
- R6: When one operand is 1, `prod_bcd` is {4'h0, other operand}.
- R7: `prod_bcd[0]` equals the AND of the two operands' least significant bits.
- R8: The output is a combinational function of the inputs and is valid in the same cycle that new operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_digit | input | 4 | Multiplicand, one decimal digit coded 0..9 |
| mplier_digit | input | 4 | Multiplier, one decimal digit coded 0..9 |
| prod_bcd | output | 8 | Product: tens digit in [7:4], units digit in [3:0] |

## Verification
All 100 valid operand pairs are applied. A new pair is driven every cycle, so a result that lags its operands would be read against the wrong pair. Zero operands and unit operands separate a faulty partial-product grid or a faulty tree column from a faulty converter, because they give products whose tens digit is 0. Products of 10 and above, with 81 at the top, exercise the add-3 correction in both decimal columns. Comparing each result with the result for the swapped pair exposes any asymmetric wiring in the tree.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;
    localparam int DIGIT_W = 4;
    localparam int PROD_W  = 2 * DIGIT_W;
    localparam int DEC_COL = (PROD_W * 3 + 9) / 10;
    localparam int DEC_W   = DEC_COL * 4;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [PROD_W-1:0]  bin_prod_t;

    // sum in bit 0, carry in bit 1
    function automatic logic [1:0] half_add(input logic x, input logic y);
        return {x & y, x ^ y};
    endfunction

    function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction
endpackage

// File: rtl/bcdmul_pp_grid.sv
module bcdmul_pp_grid
    import bcdmul_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W*W-1:0] pp_bits
);
    // pp_bits[i*W + j] = opa[i] & opb[j]
    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_col
            assign pp_bits[i*W + j] = opa[i] & opb[j];
        end
    end
endmodule

// File: rtl/bcdmul_wallace4.sv
module bcdmul_wallace4
    import bcdmul_pkg::*;
(
    input  logic [15:0]      pp_bits,
    output logic [PROD_W-1:0] bin_prod
);
    logic [1:0] l1_c1, l1_c2, l1_c3, l1_c4, l1_c5;
    logic [1:0] l2_c3, l2_c4, l2_c5, l2_c6;
    logic [PROD_W-1:0] row_x, row_y;
    logic [PROD_W:0]   rip_c;

    // first level: columns of weight 2..32
    assign l1_c1 = half_add(pp_bits[4],  pp_bits[1]);
    assign l1_c2 = full_add(pp_bits[8],  pp_bits[5],  pp_bits[2]);
    assign l1_c3 = full_add(pp_bits[12], pp_bits[9],  pp_bits[6]);
    assign l1_c4 = full_add(pp_bits[13], pp_bits[10], pp_bits[7]);
    assign l1_c5 = half_add(pp_bits[14], pp_bits[11]);

    // second level: leave every column with at most two bits
    assign l2_c3 = full_add(l1_c3[0], pp_bits[3],  l1_c2[1]);
    assign l2_c4 = half_add(l1_c4[0], l1_c3[1]);
    assign l2_c5 = half_add(l1_c5[0], l1_c4[1]);
    assign l2_c6 = half_add(pp_bits[15], l1_c5[1]);

    assign row_x = {l2_c6[1], l2_c6[0], l2_c5[0], l2_c4[0],
                    l2_c3[0], l1_c2[0], l1_c1[0], pp_bits[0]};
    assign row_y = {1'b0, l2_c5[1], l2_c4[1], l2_c3[1],
                    1'b0, l1_c1[1], 1'b0, 1'b0};

    // final carry-propagate merge of the two rows
    assign rip_c[0] = 1'b0;
    for (genvar k = 0; k < PROD_W; k++) begin : g_cpa
        logic [1:0] fa_o;
        assign fa_o       = full_add(row_x[k], row_y[k], rip_c[k]);
        assign bin_prod[k] = fa_o[0];
        assign rip_c[k+1] = fa_o[1];
    end
endmodule

// File: rtl/bcdmul_add3_cell.sv
module bcdmul_add3_cell (
    input  logic [3:0] col_in,
    output logic [3:0] col_out
);
    always_comb begin
        if (col_in >= 4'd5) col_out = col_in + 4'd3;
        else                col_out = col_in;
    end
endmodule

// File: rtl/bcdmul_bin2dec.sv
module bcdmul_bin2dec
    import bcdmul_pkg::*;
#(
    parameter int BIN_W = PROD_W,
    parameter int NCOL  = DEC_COL
) (
    input  logic [BIN_W-1:0]  bin_in,
    output logic [NCOL*4-1:0] dec_out
);
    localparam int CW = NCOL * 4;
    localparam int SW = CW + BIN_W;

    logic [SW-1:0] scr [0:BIN_W];
    assign scr[0] = {{CW{1'b0}}, bin_in};

    for (genvar s = 0; s < BIN_W; s++) begin : g_step
        logic [CW-1:0] adj;
        for (genvar d = 0; d < NCOL; d++) begin : g_dcol
            bcdmul_add3_cell u_fix (
                .col_in (scr[s][BIN_W + 4*d +: 4]),
                .col_out(adj[4*d +: 4])
            );
        end
        assign scr[s+1] = {adj[CW-2:0], scr[s][BIN_W-1:0], 1'b0};
    end

    assign dec_out = scr[BIN_W][SW-1:BIN_W];
endmodule

// File: rtl/bcd_digit_mult.sv
module bcd_digit_mult
    import bcdmul_pkg::*;
(
    input  logic [3:0] mcand_digit,
    input  logic [3:0] mplier_digit,
    output logic [7:0] prod_bcd
);
    logic [DIGIT_W*DIGIT_W-1:0] pp_bits;
    logic [PROD_W-1:0]          bin_prod;
    logic [DEC_W-1:0]           dec_cols;

    bcdmul_pp_grid #(.W(DIGIT_W)) u_grid (
        .opa    (mcand_digit),
        .opb    (mplier_digit),
        .pp_bits(pp_bits)
    );

    bcdmul_wallace4 u_tree (
        .pp_bits (pp_bits),
        .bin_prod(bin_prod)
    );

    bcdmul_bin2dec #(.BIN_W(PROD_W), .NCOL(DEC_COL)) u_conv (
        .bin_in (bin_prod),
        .dec_out(dec_cols)
    );

    // hundreds column is always zero for valid digits and is dropped
    assign prod_bcd = dec_cols[7:0];
endmodule

// File: rtl/bcdmul_checker.sv
module bcdmul_checker (
    input logic [3:0] mcand_digit,
    input logic [3:0] mplier_digit,
    input logic [7:0] prod_bcd
);
    always_comb begin
        if (!$isunknown({mcand_digit, mplier_digit, prod_bcd})
            && mcand_digit <= 4'd9 && mplier_digit <= 4'd9) begin
            p_value_r1: assert (32'(prod_bcd[7:4]) * 10 + 32'(prod_bcd[3:0])
                                == 32'(mcand_digit) * 32'(mplier_digit));
            if (mcand_digit == 4'd0 || mplier_digit == 4'd0)
                p_zero_r2: assert (prod_bcd == 8'h00);
            p_units_range_r4: assert (prod_bcd[3:0] <= 4'd9);
            p_tens_range_r4:  assert (prod_bcd[7:4] <= 4'd9);
            if (mcand_digit == 4'd1)
                p_unit_a_r6: assert (prod_bcd == {4'h0, mplier_digit});
            if (mplier_digit == 4'd1)
                p_unit_b_r6: assert (prod_bcd == {4'h0, mcand_digit});
            p_lsb_r7: assert (prod_bcd[0] == (mcand_digit[0] & mplier_digit[0]));
        end
    end
endmodule

bind bcd_digit_mult bcdmul_checker u_chk (
    .mcand_digit (mcand_digit),
    .mplier_digit(mplier_digit),
    .prod_bcd    (prod_bcd)
);

// File: tb/test_bcd_digit_mult.sv
module test_bcd_digit_mult;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_in = 4'd0;
    logic [3:0] b_in = 4'd0;
    logic [7:0] prod;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    bit         reported = 1'b0;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
        logic [7:0] exp;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] seen [0:9][0:9];

    always #4 clk = ~clk;

    bcd_digit_mult i_bcd_digit_mult (
        .mcand_digit (a_in),
        .mplier_digit(b_in),
        .prod_bcd    (prod)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d got=%h expected=%h", req, a_in, b_in, got, want);
        end
    endtask

    task automatic drive(input int a, input int b);
        item_t it;
        @(negedge clk);
        a_in = 4'(a);
        b_in = 4'(b);
        it.a   = 4'(a);
        it.b   = 4'(b);
        it.exp = {4'((a * b) / 10), 4'((a * b) % 10)};
        sb_q.push_back(it);
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    // monitor: one new pair per cycle, sampled at the next rising edge (R8)
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            string tag;
            it = sb_q.pop_front();
            if (it.a == 4'd0 || it.b == 4'd0)      tag = "R2";
            else if (it.a == 4'd9 && it.b == 4'd9) tag = "R3";
            else if (it.a == 4'd1 || it.b == 4'd1) tag = "R6";
            else                                   tag = "R1/R8";
            check(tag, prod, it.exp);
            check("R4", {3'b0, (prod[7:4] > 4'd9), 3'b0, (prod[3:0] > 4'd9)}, 8'h00);
            check("R7", {7'b0, prod[0]}, {7'b0, it.a[0] & it.b[0]});
            seen[it.a][it.b] = prod;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset", prod, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                drive(a, b);
            end
        end
        @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < 10; a++) begin
            for (int b = a + 1; b < 10; b++) begin
                n_chk++;
                if (seen[a][b] !== seen[b][a]) begin
                    n_bad++;
                    $display("FAIL R5 a=%0d b=%0d got=%h expected=%h", a, b, seen[a][b], seen[b][a]);
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule